// File: doc/BRIEF.md
# Arithmetic Fault Trap Detector

This block sits beside a DSP datapath and watches each operation as it completes. It looks for four kinds of arithmetic fault and turns any of them into one trap request. The faults are a divide whose divisor is zero, a 40-bit accumulator result that leaves the 32-bit main field, an accumulator that wraps around the ends of its full 40-bit range, and a barrel-shift count outside the legal window. A zero divisor also raises an abort to the divider in the same cycle, so the divide stops at the next clock boundary.

The faulting operation always completes. The trap request follows as a one-cycle pulse on the next cycle. Six sticky flags record which faults occurred, and software clears a flag by writing 1 to it. Overflow out of bit 31 and the full-range wrap each have their own enable per accumulator, and each has its own saturation qualifier. The arithmetic itself and the trap dispatch are outside this block.

Top module: `dsp_math_trap`

## Requirements
- R1: When `op_valid_i` is 1, `op_class_i` is 2'b01 (divide) and `divisor_i` is zero, `div_abort_o` is 1 in that same cycle and flag bit 0 is set. No enable is needed. `div_abort_o` is 0 for any other divisor or class.
- R2: In an accumulator operation (`op_class_i` = 2'b10), accumulator X (A is index 0, B is index 1) raises overflow when `acc_we_i[X]` is 1, the pre value has bits 39:31 all equal, and the post value does not. The overflow sets flag bit 1 (A) or 2 (B). It does so only when `ovf_en_i[X]` is 1 and `guard_use_i[X]` is 0.
- R3: In an accumulator operation, a written accumulator raises a catastrophic overflow when bit 39 differs between pre and post, and bit 38 differs from bit 39 in both values. This sets flag bit 3 (A) or 4 (B). It does so only when `cat_en_i[X]` is 1, `sat_acc_i[X]` is 0 and `sat_wr_i` is 0.
- R4: In a shift operation (`op_class_i` = 2'b11), `shift_amt_i` is read as a 6-bit two's-complement count. A magnitude above 16 sets flag bit 5. Counts from -16 to +16 do not.
- R5: Any fault in a cycle gives `trap_o` = 1 for exactly the next cycle. Several faults in one cycle still give one pulse, and every matching flag is set.
- R6: Flags are sticky. Writing 1 on `flag_clr_i[k]` clears bit k, and the other bits are unaffected. When a bit is set and cleared in the same cycle, the set wins.
- R7: No fault is detected while `op_valid_i` is 0. A check runs only for its own operation class and, for accumulator checks, only for a written accumulator.
- R8: After reset, `flags_o`, `trap_o` and `div_abort_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation completes this cycle |
| op_class_i | input | 2 | 00 other, 01 divide, 10 accumulator, 11 shift |
| divisor_i | input | 16 | Divisor of the divide |
| acc_a_pre_i | input | 40 | Accumulator A before the operation |
| acc_a_post_i | input | 40 | Accumulator A after the operation |
| acc_b_pre_i | input | 40 | Accumulator B before the operation |
| acc_b_post_i | input | 40 | Accumulator B after the operation |
| acc_we_i | input | 2 | Accumulator written (bit 0 A, bit 1 B) |
| ovf_en_i | input | 2 | Enable for the bit-31 overflow trap per accumulator |
| cat_en_i | input | 2 | Enable for the catastrophic overflow trap per accumulator |
| guard_use_i | input | 2 | Guard bits in use per accumulator |
| sat_acc_i | input | 2 | Accumulator saturation on per accumulator |
| sat_wr_i | input | 1 | Write-back saturation on |
| shift_amt_i | input | 6 | Signed shift count |
| flag_clr_i | input | 6 | Write-1-to-clear strobes for the flags |
| trap_o | output | 1 | Trap request pulse |
| div_abort_o | output | 1 | Abort the divide at this cycle boundary |
| flags_o | output | 6 | Sticky cause flags: 0 div, 1 ovf A, 2 ovf B, 3 cat A, 4 cat B, 5 shift |

## Verification
The assertions assume that `op_class_i` and the accumulator and control inputs are stable for the whole cycle in which `op_valid_i` is high. They also assume that no single operation moves an accumulator by more than a quarter of its 40-bit range, which is what makes the bit-38/bit-39 test a real wrap. The stimulus changes inputs only on the falling edge and holds them for a full cycle. The wrap vectors are chosen as small steps across the range ends. Each step is 0x20, and the sign-flip case that is not a wrap is a step of 10.

// File: rtl/dsp_math_trap_pkg.sv
package dsp_math_trap_pkg;
  typedef enum logic [1:0] {
    OP_OTHER = 2'b00,
    OP_DIV   = 2'b01,
    OP_ACC   = 2'b10,
    OP_SHIFT = 2'b11
  } op_class_e;

  localparam int unsigned NUM_ACC   = 2;
  localparam int unsigned NUM_CAUSE = 6;
  localparam int unsigned C_DIV     = 0;
  localparam int unsigned C_OVF0    = 1;  // A, B follow
  localparam int unsigned C_CAT0    = 3;  // A, B follow
  localparam int unsigned C_SHIFT   = 5;
endpackage

// File: rtl/dsp_math_trap_acc_chk.sv
module dsp_math_trap_acc_chk #(
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned MAIN_W = 32
) (
  input  logic [ACC_W-1:0] pre_i,
  input  logic [ACC_W-1:0] post_i,
  input  logic             check_i,
  input  logic             ovf_en_i,
  input  logic             cat_en_i,
  input  logic             guard_use_i,
  input  logic             sat_any_i,
  output logic             ovf_hit_o,
  output logic             cat_hit_o
);
  localparam int unsigned HI_W = ACC_W - MAIN_W + 1;

  logic [HI_W-1:0] pre_hi, post_hi;
  logic pre_fits, post_fits, changed, wrapped;

  always_comb begin
    pre_hi    = pre_i[ACC_W-1:MAIN_W-1];
    post_hi   = post_i[ACC_W-1:MAIN_W-1];
    pre_fits  = (&pre_hi) | ~(|pre_hi);
    post_fits = (&post_hi) | ~(|post_hi);
    changed   = (pre_i != post_i);
    // sign flip with both ends in the outer quarter: wrap across +max/-max
    wrapped   = (pre_i[ACC_W-1] != post_i[ACC_W-1]) &&
                (pre_i[ACC_W-2] != pre_i[ACC_W-1]) &&
                (post_i[ACC_W-2] != post_i[ACC_W-1]);
    ovf_hit_o = check_i && changed && pre_fits && !post_fits &&
                ovf_en_i && !guard_use_i;
    cat_hit_o = check_i && changed && wrapped && cat_en_i && !sat_any_i;
  end
endmodule

// File: rtl/dsp_math_trap_misc_chk.sv
module dsp_math_trap_misc_chk #(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned SHW       = 6,
  parameter int unsigned MAX_SHIFT = 16
) (
  input  logic             div_chk_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             shift_chk_i,
  input  logic [SHW-1:0]   shift_amt_i,
  output logic             div_zero_o,
  output logic             shift_bad_o
);
  logic [SHW-1:0] mag;

  always_comb begin
    mag         = shift_amt_i[SHW-1] ? (~shift_amt_i + 1'b1) : shift_amt_i;
    div_zero_o  = div_chk_i && (divisor_i == '0);
    shift_bad_o = shift_chk_i && (32'(mag) > MAX_SHIFT);
  end
endmodule

// File: rtl/dsp_math_trap_flags.sv
module dsp_math_trap_flags #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o,
  output logic         trap_o
);
  logic [N-1:0] flags_q;
  logic         trap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      trap_q  <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_i) | set_i;
      trap_q  <= |set_i;
    end
  end

  assign flags_o = flags_q;
  assign trap_o  = trap_q;

  AST_TRAP_AFTER_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> trap_o); // R5
  AST_TRAP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|set_i) |=> !trap_o); // R5
  AST_FLAG_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flags_o) & ~$past(clr_i) & ~flags_o) == '0)); // R6
endmodule

// File: rtl/dsp_math_trap.sv
module dsp_math_trap
  import dsp_math_trap_pkg::*;
#(
  parameter int unsigned ACC_W     = 40,
  parameter int unsigned MAIN_W    = 32,
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned SHW       = 6,
  parameter int unsigned MAX_SHIFT = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 op_valid_i,
  input  logic [1:0]           op_class_i,
  input  logic [DIV_W-1:0]     divisor_i,
  input  logic [ACC_W-1:0]     acc_a_pre_i,
  input  logic [ACC_W-1:0]     acc_a_post_i,
  input  logic [ACC_W-1:0]     acc_b_pre_i,
  input  logic [ACC_W-1:0]     acc_b_post_i,
  input  logic [NUM_ACC-1:0]   acc_we_i,
  input  logic [NUM_ACC-1:0]   ovf_en_i,
  input  logic [NUM_ACC-1:0]   cat_en_i,
  input  logic [NUM_ACC-1:0]   guard_use_i,
  input  logic [NUM_ACC-1:0]   sat_acc_i,
  input  logic                 sat_wr_i,
  input  logic [SHW-1:0]       shift_amt_i,
  input  logic [NUM_CAUSE-1:0] flag_clr_i,
  output logic                 trap_o,
  output logic                 div_abort_o,
  output logic [NUM_CAUSE-1:0] flags_o
);
  op_class_e cls;
  logic div_chk, acc_chk, shift_chk, div_zero, shift_bad;
  logic [ACC_W-1:0]     pre_v  [NUM_ACC];
  logic [ACC_W-1:0]     post_v [NUM_ACC];
  logic [NUM_ACC-1:0]   ovf_hit, cat_hit;
  logic [NUM_CAUSE-1:0] cause;

  always_comb begin
    cls       = op_class_e'(op_class_i);
    div_chk   = op_valid_i && (cls == OP_DIV);
    acc_chk   = op_valid_i && (cls == OP_ACC);
    shift_chk = op_valid_i && (cls == OP_SHIFT);
    pre_v[0]  = acc_a_pre_i;
    post_v[0] = acc_a_post_i;
    pre_v[1]  = acc_b_pre_i;
    post_v[1] = acc_b_post_i;
  end

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    dsp_math_trap_acc_chk #(.ACC_W(ACC_W), .MAIN_W(MAIN_W)) u_chk (
      .pre_i       (pre_v[g]),
      .post_i      (post_v[g]),
      .check_i     (acc_chk && acc_we_i[g]),
      .ovf_en_i    (ovf_en_i[g]),
      .cat_en_i    (cat_en_i[g]),
      .guard_use_i (guard_use_i[g]),
      .sat_any_i   (sat_acc_i[g] | sat_wr_i),
      .ovf_hit_o   (ovf_hit[g]),
      .cat_hit_o   (cat_hit[g])
    );
    assign cause[C_OVF0+g] = ovf_hit[g];
    assign cause[C_CAT0+g] = cat_hit[g];
  end

  dsp_math_trap_misc_chk #(.DIV_W(DIV_W), .SHW(SHW), .MAX_SHIFT(MAX_SHIFT)) u_misc (
    .div_chk_i   (div_chk),
    .divisor_i   (divisor_i),
    .shift_chk_i (shift_chk),
    .shift_amt_i (shift_amt_i),
    .div_zero_o  (div_zero),
    .shift_bad_o (shift_bad)
  );

  assign cause[C_DIV]   = div_zero;
  assign cause[C_SHIFT] = shift_bad;
  assign div_abort_o    = div_zero;

  dsp_math_trap_flags #(.N(NUM_CAUSE)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (cause),
    .clr_i   (flag_clr_i),
    .flags_o (flags_o),
    .trap_o  (trap_o)
  );

  AST_ABORT_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_abort_o |=> (trap_o && flags_o[C_DIV])); // R1
  AST_ABORT_ONLY_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_class_i != OP_DIV) |-> !div_abort_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> (cause == '0)); // R7
  AST_GUARD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (guard_use_i & ovf_hit) == '0); // R2
  AST_SAT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_wr_i |-> (cat_hit == '0)); // R3
  AST_SHIFT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_amt_i == '0) |-> !cause[C_SHIFT]); // R4
endmodule

// File: tb/dsp_math_trap_test.sv
module dsp_math_trap_test;
  typedef struct packed {
    logic [1:0]  cls;
    logic [15:0] dv;
    logic [39:0] ap, aq, bp, bq;
    logic [1:0]  we, oe, ce, gu, sa;
    logic        sw;
    logic [5:0]  sh;
    logic [5:0]  ex;
  } vec_t;

  localparam logic [39:0] P_IN  = 40'h00_7FFF_FFF0, P_OUT = 40'h00_8000_0010;
  localparam logic [39:0] N_IN  = 40'hFF_8000_0000, N_OUT = 40'hFF_7FFF_FFF0;
  localparam logic [39:0] TOP   = 40'h7F_FFFF_FFF0, BOT   = 40'h80_0000_0010;
  localparam logic [39:0] SMP   = 40'h00_0000_0005, SMN   = 40'hFF_FFFF_FFFB;
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 16'd0, P_IN, P_OUT, 40'd0, 40'd0, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 6'd0, 6'b000001},
    '{2'b01, 16'd5, 40'd0, 40'd0, 40'd0, 40'd0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 6'd0, 6'b000000},
    '{2'b10, 16'd0, P_IN, P_OUT, 40'd0, 40'd0, 2'b01, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 6'd0, 6'b000010},
    '{2'b10, 16'd1, P_IN, P_OUT, 40'd0, 40'd0, 2'b01, 2'b11, 2'b00, 2'b01, 2'b00, 1'b0, 6'd0, 6'b000000},
    '{2'b10, 16'd1, 40'd0, 40'd0, N_IN, N_OUT, 2'b10, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 6'd0, 6'b000100},
    '{2'b10, 16'd1, 40'd0, 40'd0, N_IN, N_OUT, 2'b10, 2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 6'd0, 6'b000000},
    '{2'b10, 16'd1, TOP, BOT, 40'd0, 40'd0, 2'b01, 2'b11, 2'b01, 2'b00, 2'b00, 1'b0, 6'd0, 6'b001000},
    '{2'b10, 16'd1, TOP, BOT, 40'd0, 40'd0, 2'b01, 2'b11, 2'b01, 2'b00, 2'b01, 1'b0, 6'd0, 6'b000000},
    '{2'b10, 16'd1, TOP, BOT, 40'd0, 40'd0, 2'b01, 2'b11, 2'b01, 2'b00, 2'b00, 1'b1, 6'd0, 6'b000000},
    '{2'b10, 16'd1, 40'd0, 40'd0, BOT, TOP, 2'b10, 2'b00, 2'b10, 2'b00, 2'b00, 1'b0, 6'd0, 6'b010000},
    '{2'b10, 16'd1, P_IN, P_OUT, BOT, TOP, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 6'd0, 6'b010010},
    '{2'b11, 16'd1, 40'd0, 40'd0, 40'd0, 40'd0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 6'd16, 6'b000000},
    '{2'b11, 16'd1, 40'd0, 40'd0, 40'd0, 40'd0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 6'd17, 6'b100000},
    '{2'b11, 16'd1, 40'd0, 40'd0, 40'd0, 40'd0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 6'h30, 6'b000000},
    '{2'b11, 16'd1, 40'd0, 40'd0, 40'd0, 40'd0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 6'h2F, 6'b100000},
    '{2'b11, 16'd1, 40'd0, 40'd0, 40'd0, 40'd0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 6'h20, 6'b100000},
    '{2'b10, 16'd1, SMP, SMN, SMN, SMP, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 6'd0, 6'b000000},
    '{2'b10, 16'd1, P_IN, P_OUT, BOT, TOP, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 6'd0, 6'b000000},
    '{2'b11, 16'd0, 40'd0, 40'd0, 40'd0, 40'd0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 6'd0, 6'b000000},
    '{2'b01, 16'd0, P_IN, P_OUT, BOT, TOP, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 6'd40, 6'b000001}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic op_valid_i, sat_wr_i;
  logic [1:0] op_class_i, acc_we_i, ovf_en_i, cat_en_i, guard_use_i, sat_acc_i;
  logic [15:0] divisor_i;
  logic [39:0] acc_a_pre_i, acc_a_post_i, acc_b_pre_i, acc_b_post_i;
  logic [5:0] shift_amt_i, flag_clr_i, flags_o;
  logic trap_o, div_abort_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dsp_math_trap uut (.*);

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    op_valid_i = 1'b0; op_class_i = 2'b00; divisor_i = 16'd1;
    acc_a_pre_i = '0; acc_a_post_i = '0; acc_b_pre_i = '0; acc_b_post_i = '0;
    acc_we_i = '0; ovf_en_i = '0; cat_en_i = '0; guard_use_i = '0; sat_acc_i = '0;
    sat_wr_i = 1'b0; shift_amt_i = '0;
  endtask

  task automatic drive(input vec_t v);
    op_valid_i = 1'b1; op_class_i = v.cls; divisor_i = v.dv;
    acc_a_pre_i = v.ap; acc_a_post_i = v.aq; acc_b_pre_i = v.bp; acc_b_post_i = v.bq;
    acc_we_i = v.we; ovf_en_i = v.oe; cat_en_i = v.ce; guard_use_i = v.gu;
    sat_acc_i = v.sa; sat_wr_i = v.sw; shift_amt_i = v.sh;
  endtask

  task automatic clear_all();
    flag_clr_i = '1;
    @(negedge clk_i);
    flag_clr_i = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    flag_clr_i = '0;
    repeat (2) @(negedge clk_i);
    chk(flags_o == 0 && !trap_o && !div_abort_o, "R8 reset", {33'd0, flags_o, trap_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(flags_o == 0 && !trap_o, "R8 after reset", {34'd0, flags_o}, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      #1;
      chk(div_abort_o == VECS[i].ex[0], $sformatf("R1 abort vec %0d", i), div_abort_o, VECS[i].ex[0]);
      @(negedge clk_i);
      idle();
      chk(flags_o == VECS[i].ex, $sformatf("R2/R3/R4/R7 flags vec %0d", i), flags_o, VECS[i].ex);
      chk(trap_o == (|VECS[i].ex), $sformatf("R5 trap vec %0d", i), trap_o, |VECS[i].ex);
      clear_all();
      chk(flags_o == 0 && !trap_o, $sformatf("R6 clear vec %0d", i), flags_o, 0);
    end

    // R1 / R7: divide with zero divisor while not valid
    op_class_i = 2'b01; divisor_i = '0; op_valid_i = 1'b0;
    #1 chk(!div_abort_o, "R7 abort idle", div_abort_o, 0);
    @(negedge clk_i);
    chk(flags_o == 0 && !trap_o, "R7 no flag idle", flags_o, 0);
    idle();

    // R5 single pulse, R6 sticky and selective clear
    drive(VECS[10]);
    @(negedge clk_i);
    idle();
    chk(trap_o, "R5 multi-cause pulse", trap_o, 1);
    @(negedge clk_i);
    chk(!trap_o, "R5 pulse one cycle", trap_o, 0);
    chk(flags_o == 6'b010010, "R6 sticky", flags_o, 6'b010010);
    flag_clr_i = 6'b000010;
    @(negedge clk_i);
    flag_clr_i = '0;
    chk(flags_o == 6'b010000, "R6 selective clear", flags_o, 6'b010000);

    // R6 set wins over clear; R5 back-to-back
    drive(VECS[12]);
    flag_clr_i = 6'b100000;
    @(negedge clk_i);
    flag_clr_i = '0;
    drive(VECS[0]);
    chk(flags_o == 6'b110000 && trap_o, "R6 set beats clear", flags_o, 6'b110000);
    @(negedge clk_i);
    idle();
    chk(trap_o && flags_o == 6'b110001, "R5 back-to-back", flags_o, 6'b110001);
    @(negedge clk_i);
    chk(!trap_o, "R5 pulse ends", trap_o, 0);
    clear_all();
    chk(flags_o == 0, "R6 clear all", flags_o, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule